// File: doc/BRIEF.md
# Path Remote Defect Persistence Detector

This block watches the three-bit remote defect field carried in the path status byte of each received frame. One sample arrives per frame, and the block judges it against three defect classes: remote server, remote connectivity and remote payload. Each class has a persistence filter. A class is declared only after ten frames in a row carry its codes. It is terminated only after ten frames in a row carry none of its codes. The three resulting defect levels are meant to feed a latching status register further downstream.

Samples enter on a valid/ready stream. A sample is taken on any clock where `in_valid` and `in_ready` are both high. `in_ready` is high except while `hold` is asserted. During hold the upstream framer must keep its sample or drop it, because nothing is consumed and every counter and output stays frozen. This is how loss-of-frame conditions are kept from counting as evidence. A separate `conn_mask` pin forces the connectivity output low for systems that do not support that defect.

Top module: `rdi_path_rx_detector`

## Requirements
- R1: After reset, `srv_defect`, `conn_defect` and `pay_defect` are all 0 and `in_ready` is 1.
- R2: `srv_defect` rises on the clock edge that accepts the tenth consecutive sample whose code is 3'b100, 3'b101 or 3'b111. These three codes may be mixed freely within the run.
- R3: Once declared, `srv_defect` falls on the edge that accepts the tenth consecutive sample whose code is not 3'b100, 3'b101 or 3'b111.
- R4: The connectivity defect is declared after ten consecutive accepted samples of 3'b110. It is terminated after ten consecutive accepted samples of any other code.
- R5: `pay_defect` is declared after ten consecutive accepted samples of 3'b010. It is terminated after ten consecutive accepted samples of any other code.
- R6: A single accepted sample that breaks a run restarts that class's count. After nine matching samples and one other sample, a further ten matching samples are needed to change the defect level.
- R7: Codes 3'b000, 3'b001 and 3'b011 are not evidence for any defect. Any number of them leaves all defect outputs at 0.
- R8: Only accepted samples count. Clocks with `in_valid` low do not advance any count and do not break any run.
- R9: While `hold` is 1, `in_ready` is 0, offered samples are not consumed, and all defect outputs keep their values. Counting resumes from the frozen state when `hold` returns to 0.
- R10: While `conn_mask` is 1, `conn_defect` is 0. The connectivity filter keeps tracking, so clearing the mask shows its current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame's defect code is offered |
| in_ready | output | 1 | Block consumes the offered code (low during hold) |
| in_code | input | 3 | Remote defect field of the path status byte |
| hold | input | 1 | Freeze all filtering (e.g. during loss of frame) |
| conn_mask | input | 1 | Suppress the connectivity defect output |
| srv_defect | output | 1 | Remote server defect level |
| conn_defect | output | 1 | Remote connectivity defect level (masked) |
| pay_defect | output | 1 | Remote payload defect level |

## Verification
The hardest state to reach from the ports is a run that is broken one sample short of its threshold. A nine-sample run looks exactly like an idle filter at the outputs, so the stimulus first establishes a defect. It then sends nine samples toward termination, injects one matching code, and checks that ten more samples are still required. A similar sequence covers hold and idle gaps placed inside an open run: the bench checks that the count neither advanced nor restarted, by counting the samples until the level changes.

// File: rtl/rdi_pkg.sv
package rdi_pkg;
  localparam int CODE_W  = 3;
  localparam int NUM_DEF = 3;

  typedef enum int {
    DEF_SRV  = 0,
    DEF_CONN = 1,
    DEF_PAY  = 2
  } defect_e;

  localparam logic [CODE_W-1:0] CODE_SRV_A = 3'b101;
  localparam logic [CODE_W-1:0] CODE_SRV_B = 3'b100;
  localparam logic [CODE_W-1:0] CODE_SRV_C = 3'b111;
  localparam logic [CODE_W-1:0] CODE_CONN  = 3'b110;
  localparam logic [CODE_W-1:0] CODE_PAY   = 3'b010;
endpackage

// File: rtl/rdi_classify.sv
module rdi_classify
  import rdi_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  output logic [NUM_DEF-1:0] hit
);
  always_comb begin
    hit = '0;
    hit[DEF_SRV]  = (code == CODE_SRV_A) || (code == CODE_SRV_B) || (code == CODE_SRV_C);
    hit[DEF_CONN] = (code == CODE_CONN);
    hit[DEF_PAY]  = (code == CODE_PAY);
  end
endmodule

// File: rtl/rdi_persist.sv
module rdi_persist #(
  parameter int PERSIST = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic hit,
  output logic level
);
  localparam int CNT_W = $clog2(PERSIST + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

  logic [CNT_W-1:0] run;

  // run counts consecutive samples disagreeing with the current level
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      run   <= '0;
    end else if (take) begin
      if (hit != level) begin
        if (run == LAST) begin
          level <= ~level;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(level) && $stable(run)));

  a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run < CNT_W'(PERSIST));

  a_r2_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> ($past(hit) && $past(take)));

  a_r3_fall_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level) |-> (!$past(hit) && $past(take)));
endmodule

// File: rtl/rdi_path_rx_detector.sv
module rdi_path_rx_detector
  import rdi_pkg::*;
#(
  parameter int PERSIST = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic              hold,
  input  logic              conn_mask,
  output logic              srv_defect,
  output logic              conn_defect,
  output logic              pay_defect
);
  logic [NUM_DEF-1:0] hit;
  logic [NUM_DEF-1:0] lvl;
  logic               take;

  assign in_ready = ~hold;
  assign take     = in_valid & in_ready;

  rdi_classify u_cls (
    .code (in_code),
    .hit  (hit)
  );

  for (genvar d = 0; d < NUM_DEF; d++) begin : g_def
    rdi_persist #(.PERSIST(PERSIST)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .hit   (hit[d]),
      .level (lvl[d])
    );
  end

  assign srv_defect  = lvl[DEF_SRV];
  assign conn_defect = lvl[DEF_CONN] & ~conn_mask;
  assign pay_defect  = lvl[DEF_PAY];

  // a run that declares one class is a terminating run for the others
  a_r4_classes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl));

  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(srv_defect) && $stable(pay_defect)));

  a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    conn_mask |-> !conn_defect);
endmodule

// File: tb/rdi_path_rx_detector_test.sv
module rdi_path_rx_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic clk = 0, rst_n = 0, in_valid = 0, hold = 0, conn_mask = 0;
  logic [2:0] in_code = 3'b000;
  logic in_ready, srv_defect, conn_defect, pay_defect;

  int tests = 0, fails = 0;
  string tag = "R1";
  logic [2:0] expq[$];
  logic [2:0] tagdummy;

  // bench view of each class: level and run length
  logic ref_lvl[3];
  int   ref_run[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  rdi_path_rx_detector #(.PERSIST(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .hold(hold), .conn_mask(conn_mask),
    .srv_defect(srv_defect), .conn_defect(conn_defect), .pay_defect(pay_defect)
  );

  task automatic check(input string t, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] c);
    logic h[3];
    h[0] = (c == 3'b100) || (c == 3'b101) || (c == 3'b111);
    h[1] = (c == 3'b110);
    h[2] = (c == 3'b010);
    for (int d = 0; d < 3; d++) begin
      if (h[d] != ref_lvl[d]) begin
        ref_run[d]++;
        if (ref_run[d] == N) begin
          ref_lvl[d] = ~ref_lvl[d];
          ref_run[d] = 0;
        end
      end else ref_run[d] = 0;
    end
    expq.push_back({ref_lvl[2], ref_lvl[1] & ~conn_mask, ref_lvl[0]});
  endtask

  task automatic send(input logic [2:0] c, input int gap = 0);
    @(negedge clk);
    in_valid = 1; in_code = c;
    model(c);
    @(negedge clk);
    in_valid = 0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic send_n(input logic [2:0] c, input int n, input int gap = 0);
    for (int i = 0; i < n; i++) send(c, gap);
  endtask

  // monitor: compares outputs after every accepted sample
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && in_valid && in_ready) begin
        @(negedge clk);
        if (expq.size() == 0) check({tag, " unexpected sample"}, 4'b1, 4'b0);
        else check(tag, {1'b0, pay_defect, conn_defect, srv_defect}, {1'b0, expq.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check("watchdog", 4'b1, 4'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < 3; d++) begin ref_lvl[d] = 0; ref_run[d] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", {in_ready, pay_defect, conn_defect, srv_defect}, 4'b1000);

    tag = "R7 no-defect codes";
    send_n(3'b000, 12); send_n(3'b001, 12); send_n(3'b011, 12);

    tag = "R2 server declare mixed codes";
    for (int i = 0; i < 10; i++) send((i % 3 == 0) ? 3'b101 : (i % 3 == 1) ? 3'b100 : 3'b111);
    send_n(3'b101, 4);

    tag = "R6 break before termination";
    send_n(3'b001, 9); send(3'b111);
    tag = "R3 server terminate";
    send_n(3'b000, 10);

    tag = "R6 break before declaration";
    send_n(3'b101, 9); send(3'b001); send_n(3'b101, 10);

    tag = "R5 payload declare";
    send_n(3'b010, 10);
    tag = "R5 payload terminate";
    send_n(3'b011, 10);

    tag = "R4 connectivity declare";
    send_n(3'b110, 10);
    @(negedge clk); conn_mask = 1;
    @(negedge clk);
    check("R10 mask active", {1'b0, pay_defect, conn_defect, srv_defect}, 4'b0000);
    tag = "R10 masked samples";
    send_n(3'b110, 3);
    @(negedge clk); conn_mask = 0;
    @(negedge clk);
    check("R10 mask cleared", {1'b0, pay_defect, conn_defect, srv_defect}, 4'b0010);
    tag = "R4 connectivity terminate";
    send_n(3'b001, 10);

    tag = "R8 gapped samples";
    send_n(3'b010, 5, 3);
    repeat (20) @(negedge clk);
    send_n(3'b010, 5, 2);
    send_n(3'b000, 10, 1);

    tag = "R9 prepare";
    send_n(3'b101, 10);
    send_n(3'b001, 5);
    @(negedge clk); hold = 1; in_valid = 1; in_code = 3'b001;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R9 hold", {in_ready, pay_defect, conn_defect, srv_defect}, 4'b0001);
    end
    in_valid = 0; hold = 0;
    tag = "R9 resume";
    send_n(3'b001, 5);

    repeat (5) @(negedge clk);
    check("queue drained", {1'b0, 3'(expq.size())}, 4'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule